// File: doc/BRIEF.md
# Dice Game Microcoded Controller

This block is a state-addressed microprogrammed control unit that runs the dice game. A 16-entry constant control store is indexed only by the 4-bit state register. Each control word carries four fields: a 3-bit condition selector, a jump target taken when the selected condition is false, a jump target taken when it is true, and a set of output strobes. The condition selector steers a multiplexer over the external and derived condition bits. The value of the chosen bit then picks which of the two targets is loaded into the state register at the next clock edge. Every output is a function of the current control word alone.

A small datapath sits beside the sequencer. It decodes the dice sum into "seven", "seven or eleven" and "two, three or twelve" flags. It holds the point register, which loads the sum when the microcode raises its store strobe, and it compares the sum with the stored point. The surrounding system supplies the dice sum and the roll button. While `roll` is high it advances its dice counters, and it must hold `sum` steady while `roll` is low. Decisions that would need a conditional output or a multi-way branch are split into chains of single-test states.

Top module: `dice_useq`

## Requirements
- R1: A synchronous active-high `rst` sends the sequencer to control address 0. On the cycle after a reset edge, `roll`, `win` and `lose` are low and `point` reads 0.
- R2: From an idle state, a high `btn` seen at a clock edge enters a rolling state. `roll` is high from the next cycle until the first clock edge at which `btn` is seen low, and it is low after that edge.
- R3: On the first roll of a game, a binary `sum` of 7 or 11 ends the game with `win` high and `lose` low.
- R4: On the first roll of a game, a `sum` of 2, 3 or 12 ends the game with `lose` high and `win` low.
- R5: On the first roll, any other sum (4, 5, 6, 8, 9 or 10) is copied into `point`. `win` and `lose` stay low, and the controller waits for another roll.
- R6: On a later roll, a `sum` equal to `point` gives `win`.
- R7: On a later roll, a `sum` of 7 gives `lose`. Any other sum returns to waiting for a roll, and `point` keeps its value.
- R8: `win` and `lose` hold while `clr` is low and ignore `btn`. A clock edge with `clr` high clears them and returns to the first-roll idle state.
- R9: `clr` has no effect outside the win and lose states. A point game pulsed with `clr` while idle still finishes against the stored point.
- R10: At most one of `roll`, `win` and `lose` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 1 | Roll button, high while pressed |
| clr | input | 1 | Clears a finished game |
| sum | input | 4 | Dice sum, binary 2 to 12 |
| roll | output | 1 | Dice counters advance while high |
| win | output | 1 | Game won |
| lose | output | 1 | Game lost |
| point | output | 4 | Stored point value |

## Verification
The assertions assume that `sum` lies between 2 and 12. They also assume it is steady whenever `roll` is low, because the decode states sample it over several cycles after the button is released. The stimulus sets `sum` before each button press and changes it only while the sequencer is idle. The hold and exit properties also assume `clr` and `btn` change only between edges. The bench therefore drives them just after the falling edge.

// File: rtl/dice_useq_pkg.sv
`timescale 1ns/1ps
package dice_useq_pkg;

    localparam int ST_W   = 4;
    localparam int SUM_W  = 4;
    localparam int TST_W  = 3;
    localparam int N_COND = 1 << TST_W;
    localparam int N_ADDR = 1 << ST_W;

    typedef logic [ST_W-1:0] st_t;

    typedef enum logic [TST_W-1:0] {
        TST_NONE  = 3'd0,
        TST_BTN   = 3'd1,
        TST_CLR   = 3'd2,
        TST_D7    = 3'd3,
        TST_D711  = 3'd4,
        TST_D2312 = 3'd5,
        TST_EQ    = 3'd6,
        TST_RSV   = 3'd7
    } test_e;

    typedef struct packed {
        logic roll;
        logic win;
        logic lose;
        logic sp;
    } uout_t;

    typedef struct packed {
        test_e test;
        st_t   nsf;
        st_t   nst;
        uout_t out;
    } uword_t;

    localparam st_t A_IDLE1 = 4'd0;
    localparam st_t A_ROLL1 = 4'd1;
    localparam st_t A_C711  = 4'd2;
    localparam st_t A_C2312 = 4'd3;
    localparam st_t A_STORE = 4'd4;
    localparam st_t A_WIN   = 4'd5;
    localparam st_t A_LOSE  = 4'd6;
    localparam st_t A_IDLE2 = 4'd7;
    localparam st_t A_ROLL2 = 4'd8;
    localparam st_t A_CEQ   = 4'd9;
    localparam st_t A_C7    = 4'd10;

    localparam uout_t O_NONE  = '{roll: 1'b0, win: 1'b0, lose: 1'b0, sp: 1'b0};
    localparam uout_t O_ROLL  = '{roll: 1'b1, win: 1'b0, lose: 1'b0, sp: 1'b0};
    localparam uout_t O_WIN   = '{roll: 1'b0, win: 1'b1, lose: 1'b0, sp: 1'b0};
    localparam uout_t O_LOSE  = '{roll: 1'b0, win: 1'b0, lose: 1'b1, sp: 1'b0};
    localparam uout_t O_STORE = '{roll: 1'b0, win: 1'b0, lose: 1'b0, sp: 1'b1};

    function automatic uword_t mk_word(test_e t, st_t f, st_t tr, uout_t o);
        uword_t w;
        w.test = t;
        w.nsf  = f;
        w.nst  = tr;
        w.out  = o;
        return w;
    endfunction

endpackage

// File: rtl/dice_useq_rom.sv
`timescale 1ns/1ps
module dice_useq_rom
    import dice_useq_pkg::*;
(
    input  st_t    addr,
    output uword_t word
);

    // Control store; only the state register addresses it.
    always_comb begin
        unique case (addr)
            A_IDLE1: word = mk_word(TST_BTN,   A_IDLE1, A_ROLL1, O_NONE);
            A_ROLL1: word = mk_word(TST_BTN,   A_C711,  A_ROLL1, O_ROLL);
            A_C711:  word = mk_word(TST_D711,  A_C2312, A_WIN,   O_NONE);
            A_C2312: word = mk_word(TST_D2312, A_STORE, A_LOSE,  O_NONE);
            A_STORE: word = mk_word(TST_NONE,  A_IDLE2, A_IDLE2, O_STORE);
            A_WIN:   word = mk_word(TST_CLR,   A_WIN,   A_IDLE1, O_WIN);
            A_LOSE:  word = mk_word(TST_CLR,   A_LOSE,  A_IDLE1, O_LOSE);
            A_IDLE2: word = mk_word(TST_BTN,   A_IDLE2, A_ROLL2, O_NONE);
            A_ROLL2: word = mk_word(TST_BTN,   A_CEQ,   A_ROLL2, O_ROLL);
            A_CEQ:   word = mk_word(TST_EQ,    A_C7,    A_WIN,   O_NONE);
            A_C7:    word = mk_word(TST_D7,    A_IDLE2, A_LOSE,  O_NONE);
            default: word = mk_word(TST_NONE,  A_IDLE1, A_IDLE1, O_NONE);
        endcase
    end

endmodule

// File: rtl/dice_useq_tmux.sv
`timescale 1ns/1ps
module dice_useq_tmux
    import dice_useq_pkg::*;
#(
    parameter int N_SEL = N_COND
) (
    input  logic [N_SEL-1:0] cond,
    input  test_e            sel,
    output logic             hit
);

    logic [N_SEL-1:0] term;

    // AND-OR selector: one gated term per condition code.
    for (genvar g = 0; g < N_SEL; g++) begin : g_term
        assign term[g] = cond[g] & (sel == test_e'(g));
    end

    assign hit = |term;

endmodule

// File: rtl/dice_useq_dpath.sv
`timescale 1ns/1ps
module dice_useq_dpath #(
    parameter int SW = dice_useq_pkg::SUM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sum,
    input  logic          store,
    output logic          d7,
    output logic          d711,
    output logic          d2312,
    output logic          eq,
    output logic [SW-1:0] point
);

    localparam logic [SW-1:0] V2  = SW'(2);
    localparam logic [SW-1:0] V3  = SW'(3);
    localparam logic [SW-1:0] V7  = SW'(7);
    localparam logic [SW-1:0] V11 = SW'(11);
    localparam logic [SW-1:0] V12 = SW'(12);

    logic [SW-1:0] point_q;

    always_ff @(posedge clk) begin
        if (rst)        point_q <= '0;
        else if (store) point_q <= sum;
    end

    always_comb begin
        d7    = (sum == V7);
        d711  = (sum == V7) || (sum == V11);
        d2312 = (sum == V2) || (sum == V3) || (sum == V12);
        eq    = (sum == point_q);
    end

    assign point = point_q;

endmodule

// File: rtl/dice_useq.sv
`timescale 1ns/1ps
module dice_useq
    import dice_useq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             btn,
    input  logic             clr,
    input  logic [SUM_W-1:0] sum,
    output logic             roll,
    output logic             win,
    output logic             lose,
    output logic [SUM_W-1:0] point
);

    st_t              state_q;
    st_t              state_d;
    uword_t           word;
    logic             hit;
    logic             store_pt;
    logic             d7, d711, d2312, eq;
    logic [N_COND-1:0] cond;

    dice_useq_rom u_rom (
        .addr (state_q),
        .word (word)
    );

    dice_useq_dpath #(.SW(SUM_W)) u_dpath (
        .clk   (clk),
        .rst   (rst),
        .sum   (sum),
        .store (store_pt),
        .d7    (d7),
        .d711  (d711),
        .d2312 (d2312),
        .eq    (eq),
        .point (point)
    );

    // Condition vector ordered by test code; codes 0 and 7 read false.
    assign cond = {1'b0, eq, d2312, d711, d7, clr, btn, 1'b0};

    dice_useq_tmux #(.N_SEL(N_COND)) u_tmux (
        .cond (cond),
        .sel  (word.test),
        .hit  (hit)
    );

    always_comb begin
        state_d = hit ? word.nst : word.nsf;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= A_IDLE1;
        else     state_q <= state_d;
    end

    assign store_pt = word.out.sp;
    assign roll     = word.out.roll;
    assign win      = word.out.win;
    assign lose     = word.out.lose;

endmodule

// File: rtl/dice_useq_chk.sv
`timescale 1ns/1ps
module dice_useq_chk #(
    parameter int SW = dice_useq_pkg::SUM_W
) (
    input logic          clk,
    input logic          rst,
    input logic          btn,
    input logic          clr,
    input logic          roll,
    input logic          win,
    input logic          lose,
    input logic          store,
    input logic [SW-1:0] point
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: the cycle after a reset edge shows the idle outputs and a cleared point.
    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_idle_R1: assert (!roll && !win && !lose && point == '0);
        end
    end

    assert_roll_after_btn_R2: assert property (@(posedge clk) disable iff (rst)
        roll |-> $past(btn));

    assert_roll_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (roll && !btn) |=> !roll);

    assert_point_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!store && !rst) |=> $stable(point));

    assert_win_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (win && !clr && !rst) |=> win);

    assert_lose_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (lose && !clr && !rst) |=> lose);

    assert_clr_exit_R8: assert property (@(posedge clk) disable iff (rst)
        ((win || lose) && clr) |=> (!win && !lose && !roll));

    assert_outs_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({roll, win, lose}));

endmodule

bind dice_useq dice_useq_chk #(.SW(dice_useq_pkg::SUM_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .btn   (btn),
    .clr   (clr),
    .roll  (roll),
    .win   (win),
    .lose  (lose),
    .store (store_pt),
    .point (point)
);

// File: tb/dice_useq_bench.sv
`timescale 1ns/1ps
module dice_useq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn = 1'b0;
    logic       clr = 1'b0;
    logic [3:0] sum = 4'd2;
    logic       roll, win, lose;
    logic [3:0] point;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dice_useq u_dice_useq (
        .clk   (clk),
        .rst   (rst),
        .btn   (btn),
        .clr   (clr),
        .sum   (sum),
        .roll  (roll),
        .win   (win),
        .lose  (lose),
        .point (point)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; btn = 1'b0; clr = 1'b0;
        step(2);
        rst = 1'b0;
    endtask

    // Press for two cycles, release, then let the decision states settle.
    task automatic roll_dice(input int s);
        sum = 4'(s);
        btn = 1'b1;
        step(1);
        check("R2 roll high while held", int'(roll), 1);
        step(1);
        check("R2 roll still high", int'(roll), 1);
        btn = 1'b0;
        step(1);
        check("R2 roll low after release", int'(roll), 0);
        step(5);
        check("R10 one output at most", int'(roll) + int'(win) + int'(lose) <= 1 ? 1 : 0, 1);
    endtask

    task automatic finish_game();
        btn = 1'b1;
        step(2);
        btn = 1'b0;
        step(1);
        check("R8 btn ignored, result held", int'(win || lose), 1);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        check("R8 clr clears win", int'(win), 0);
        check("R8 clr clears lose", int'(lose), 0);
    endtask

    initial begin
        step(1);
        check("R1 reset roll", int'(roll), 0);
        check("R1 reset win", int'(win), 0);
        check("R1 reset lose", int'(lose), 0);
        check("R1 reset point", int'(point), 0);

        // First-roll sweep over every legal sum.
        for (int s = 2; s <= 12; s++) begin
            do_reset();
            roll_dice(s);
            if (s == 7 || s == 11) begin
                check("R3 first-roll win", int'(win), 1);
                check("R3 first-roll no lose", int'(lose), 0);
                finish_game();
            end else if (s == 2 || s == 3 || s == 12) begin
                check("R4 first-roll lose", int'(lose), 1);
                check("R4 first-roll no win", int'(win), 0);
                finish_game();
            end else begin
                check("R5 point stored", int'(point), s);
                check("R5 no result yet", int'(win || lose), 0);
                clr = 1'b1;
                step(1);
                clr = 1'b0;
                step(1);
                check("R9 clr ignored in idle", int'(win || lose), 0);
                roll_dice(s);
                check("R9 point game still wins", int'(win), 1);
                finish_game();
            end
        end

        // Second-roll sweep for every point against every sum.
        for (int p = 4; p <= 10; p++) begin
            if (p == 7) continue;
            for (int s = 2; s <= 12; s++) begin
                do_reset();
                roll_dice(p);
                check("R5 point stored", int'(point), p);
                roll_dice(s);
                if (s == p) begin
                    check("R6 match wins", int'(win), 1);
                    check("R6 match no lose", int'(lose), 0);
                    finish_game();
                end else if (s == 7) begin
                    check("R7 seven loses", int'(lose), 1);
                    check("R7 seven no win", int'(win), 0);
                    finish_game();
                end else begin
                    check("R7 continue no result", int'(win || lose), 0);
                    check("R7 point kept", int'(point), p);
                    roll_dice(p);
                    check("R6 later match wins", int'(win), 1);
                    finish_game();
                end
            end
        end

        // Reset in the middle of a point game.
        do_reset();
        roll_dice(9);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        check("R1 mid-game reset point", int'(point), 0);
        check("R1 mid-game reset outputs", int'(roll || win || lose), 0);
        roll_dice(7);
        check("R1 back to first roll", int'(win), 1);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule